// File: doc/BRIEF.md
# Dual-slope PWM timer channel

This block is one channel of a timer that produces a phase-correct pulse-width-modulated waveform. Its counter climbs from zero to a selectable ceiling, turns, and descends back to zero, so one PWM period is twice the ceiling in clock cycles. The output edges sit symmetrically about the ceiling. A duty value is written into a holding register and is taken into use only when the counter turns at the ceiling. This keeps a period from mixing two duty values in a way that would cause glitches.

Two status flags are kept. The turnaround flag is raised when the count reverses at zero. The match flag is raised whenever the count equals the active duty value. Each flag is cleared by a one-cycle strobe and drives an interrupt request gated by its own enable and a shared global enable. A two-bit output mode turns the pin off, drives the waveform true, or drives it inverted. Duty values at zero, or at the ceiling and above, hold the pin at a constant level.

Top module: `pwm_ds_timer`

## Requirements
- R1: While `run` is high the count steps up by one per cycle from 0 to TOP, then steps down by one per cycle to 0, and repeats. One period is 2·TOP cycles. `top_sel` 00 selects TOP=255, 01 selects 511, and 10 or 11 select 1023.
- R2: The turnaround flag is set on the clock edge where the count, descending, leaves 0. After reset is released with `run` high, it is first visible on `ovf_irq` 2·TOP+1 cycles later, and then again every 2·TOP cycles.
- R3: `ovf_irq` is high exactly when the turnaround flag, `ovf_ie` and `glb_ie` are all 1. `cmp_irq` is high exactly when the match flag, `cmp_ie` and `glb_ie` are all 1. Enables only gate a request and never clear a flag.
- R4: The match flag is set on the edge after a cycle in which the count equals the active duty value. Counted from the cycle in which the count shows 1 on its way up, with duty value c, the flag becomes visible c cycles later.
- R5: A flag is cleared at the edge where its clear strobe is 1. When the flag's set condition and its clear strobe fall on the same edge, the flag ends up set.
- R6: In mode 10 (true), with duty value c where 0 < c < TOP, the output goes low in the cycle after an up-counting match and high in the cycle after a down-counting match. This gives 2·c high cycles per period.
- R7: In mode 11 (inverted), the output is the complement of mode 10, giving 2·TOP−2·c high cycles per period.
- R8: In modes 00 and 01 the output is held low.
- R9: A duty value of 0 holds the output low in mode 10 and high in mode 11. A duty value of TOP or above holds it high in mode 10 and low in mode 11.
- R10: A written duty value becomes active only at the edge where the count turns at TOP. In a period where the value changes on the way up, the old value governs the rising half and the new one the falling half.
- R11: While `run` is low the count, the direction, the output and both flags are frozen, apart from clear strobes.
- R12: Reset sets the count to 0 counting up, both duty registers to 0, and both flags to 0, so the output is low and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable |
| top_sel | input | 2 | Ceiling select: 00=255, 01=511, 1x=1023 |
| cmp_wr | input | 1 | Write strobe for the duty holding register |
| cmp_wdata | input | 10 | Duty value to write |
| out_mode | input | 2 | 00/01 off (low), 10 true, 11 inverted |
| ovf_clr | input | 1 | Clear strobe for the turnaround flag |
| cmp_clr | input | 1 | Clear strobe for the match flag |
| ovf_ie | input | 1 | Turnaround interrupt enable |
| cmp_ie | input | 1 | Match interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| pwm_out | output | 1 | PWM output |
| ovf_irq | output | 1 | Turnaround interrupt request |
| cmp_irq | output | 1 | Match interrupt request |

## Verification
A clear strobe and a flag set can land on the same clock edge. That is the one place where software action and hardware action meet. The bench aligns to a visible turnaround event and uses the fact that the next turnaround comes exactly 2·TOP edges later. It raises the clear strobe so that it is sampled on that edge, and expects `ovf_irq` to stay high afterwards, with an ordinary clear one cycle after the earlier event as the control case. A duty write on the rising half of a period is also judged by counting high cycles over the window between two turnarounds, which must equal the old value plus the new one.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

  parameter int unsigned CW = 10;
  localparam int unsigned SELW = 2;

  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    OM_OFF  = 2'b00,
    OM_RSV  = 2'b01,
    OM_TRUE = 2'b10,
    OM_INV  = 2'b11
  } out_mode_e;

  // Ceiling for a select code: (2^(CW-2))-1, (2^(CW-1))-1 or (2^CW)-1.
  function automatic cnt_t top_value(input logic [SELW-1:0] sel);
    int unsigned sh;
    sh = (sel == 2'b00) ? CW - 2 : (sel == 2'b01) ? CW - 1 : CW;
    return cnt_t'((64'd1 << sh) - 64'd1);
  endfunction

  // Duty values that pin the output at a constant level.
  function automatic logic duty_is_fixed(input cnt_t duty, input cnt_t top);
    return (duty == '0) || (duty >= top);
  endfunction

  // Constant level, before any inversion, for a pinned duty value.
  function automatic logic fixed_level(input cnt_t duty);
    return duty != '0;
  endfunction

endpackage

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter
  import pwm_ds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  cnt_t top,
  output cnt_t cnt,
  output logic down,
  output logic turn_top,
  output logic turn_bot
);

  cnt_t cnt_q;
  logic down_q;

  // Turnaround events, brought out for the compare unit and the flags.
  assign turn_top = run && !down_q && (cnt_q >= top);
  assign turn_bot = run && down_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (run) begin
      if (!down_q) begin
        if (cnt_q >= top) begin
          down_q <= 1'b1;
          cnt_q  <= cnt_q - 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_q <= 1'b0;
          cnt_q  <= cnt_q + 1'b1;
        end else begin
          cnt_q  <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt  = cnt_q;
  assign down = down_q;

  // R1: a rising step below the ceiling adds exactly one
  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !down_q && (cnt_q < top)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R1: leaving zero on the way down turns the count upward at one
  a_r1_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
    turn_bot |=> (!down_q && (cnt_q == cnt_t'(1))));

  // R11: a stopped counter does not move
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt_q) && $stable(down_q)));

endmodule

// File: rtl/pwm_ds_compare.sv
module pwm_ds_compare
  import pwm_ds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wr,
  input  cnt_t wdata,
  input  cnt_t cnt,
  input  logic down,
  input  cnt_t top,
  input  logic turn_top,
  input  logic turn_bot,
  output cnt_t duty_act,
  output logic match,
  output logic wave,
  output logic pinned,
  output logic pin_lvl
);

  cnt_t hold_q;
  cnt_t act_q;
  logic wave_q;

  assign match   = run && (cnt == act_q);
  assign pinned  = duty_is_fixed(act_q, top);
  assign pin_lvl = fixed_level(act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr) begin
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (turn_top) begin
      act_q <= hold_q;
    end
  end

  // True-polarity waveform: low around the ceiling, high around zero.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else if (turn_top) begin
      wave_q <= 1'b0;
    end else if (turn_bot) begin
      wave_q <= 1'b1;
    end else if (match) begin
      wave_q <= down;
    end
  end

  assign duty_act = act_q;
  assign wave     = wave_q;

  // R10: the active duty value changes only after a turn at the ceiling
  a_r10_load_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_top |=> $stable(act_q));

  // R6: a falling-slope match raises the waveform
  a_r6_down_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match && down && !turn_bot) |=> wave_q);

endmodule

// File: rtl/pwm_ds_flag.sv
module pwm_ds_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i & gie_i;

  // R5: a set wins over a clear on the same edge
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R5: a clear with no set empties the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

  // R3: no request without both enables
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(ie_i && gie_i) |-> !irq_o);

endmodule

// File: rtl/pwm_ds_timer.sv
module pwm_ds_timer
  import pwm_ds_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    top_sel,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic [1:0]    out_mode,
  input  logic          ovf_clr,
  input  logic          cmp_clr,
  input  logic          ovf_ie,
  input  logic          cmp_ie,
  input  logic          glb_ie,
  output logic          pwm_out,
  output logic          ovf_irq,
  output logic          cmp_irq
);

  localparam int unsigned NFLAG = 2;
  localparam int unsigned F_OVF = 0;
  localparam int unsigned F_CMP = 1;

  cnt_t top;
  cnt_t cnt;
  logic down;
  logic turn_top;
  logic turn_bot;
  cnt_t duty_act;
  logic match;
  logic wave;
  logic pinned;
  logic pin_lvl;
  logic true_lvl;

  logic [NFLAG-1:0] f_set;
  logic [NFLAG-1:0] f_clr;
  logic [NFLAG-1:0] f_ie;
  logic [NFLAG-1:0] f_flag;
  logic [NFLAG-1:0] f_irq;

  assign top = top_value(top_sel);

  pwm_ds_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .top      (top),
    .cnt      (cnt),
    .down     (down),
    .turn_top (turn_top),
    .turn_bot (turn_bot)
  );

  pwm_ds_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wr       (cmp_wr),
    .wdata    (cmp_wdata),
    .cnt      (cnt),
    .down     (down),
    .top      (top),
    .turn_top (turn_top),
    .turn_bot (turn_bot),
    .duty_act (duty_act),
    .match    (match),
    .wave     (wave),
    .pinned   (pinned),
    .pin_lvl  (pin_lvl)
  );

  assign f_set[F_OVF] = turn_bot;
  assign f_set[F_CMP] = match;
  assign f_clr[F_OVF] = ovf_clr;
  assign f_clr[F_CMP] = cmp_clr;
  assign f_ie[F_OVF]  = ovf_ie;
  assign f_ie[F_CMP]  = cmp_ie;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    pwm_ds_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .ie_i   (f_ie[g]),
      .gie_i  (glb_ie),
      .flag_o (f_flag[g]),
      .irq_o  (f_irq[g])
    );
  end

  assign ovf_irq = f_irq[F_OVF];
  assign cmp_irq = f_irq[F_CMP];

  always_comb begin
    true_lvl = pinned ? pin_lvl : wave;
    unique case (out_mode_e'(out_mode))
      OM_TRUE: pwm_out = true_lvl;
      OM_INV:  pwm_out = ~true_lvl;
      default: pwm_out = 1'b0;
    endcase
  end

  // R2: the turnaround flag only rises after a turn at zero
  a_r2_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_flag[F_OVF]) |-> $past(turn_bot));

  // R8: outputs in the off modes stay low
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode[1] |-> !pwm_out);

  // R9: zero duty in true mode pins the pin low
  a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_mode == 2'b10) && (duty_act == '0)) |-> !pwm_out);

  // R9: ceiling duty in inverted mode pins the pin low
  a_r9_full_inv_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_mode == 2'b11) && (duty_act >= top)) |-> !pwm_out);

endmodule

// File: tb/sim_pwm_ds_timer.sv
`timescale 1ns/1ps
module sim_pwm_ds_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] top_sel = 2'b00;
  logic       cmp_wr = 1'b0;
  logic [9:0] cmp_wdata = '0;
  logic [1:0] out_mode = 2'b00;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic       ovf_ie = 1'b0;
  logic       cmp_ie = 1'b0;
  logic       glb_ie = 1'b0;
  logic       pwm_out;
  logic       ovf_irq;
  logic       cmp_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwm_ds_timer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .top_sel(top_sel),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .out_mode(out_mode),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .ovf_ie(ovf_ie),
    .cmp_ie(cmp_ie), .glb_ie(glb_ie), .pwm_out(pwm_out),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  // {top_sel, mode, duty, expected high cycles per period}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 2'b10, 10'd100, 12'd200},
    {2'd0, 2'b11, 10'd100, 12'd310},
    {2'd0, 2'b10, 10'd0,   12'd0},
    {2'd0, 2'b11, 10'd0,   12'd510},
    {2'd0, 2'b10, 10'd255, 12'd510},
    {2'd0, 2'b11, 10'd255, 12'd0},
    {2'd0, 2'b00, 10'd100, 12'd0},
    {2'd1, 2'b10, 10'd300, 12'd600},
    {2'd0, 2'b10, 10'd300, 12'd510},
    {2'd2, 2'b11, 10'd1,   12'd2044},
    {2'd0, 2'b10, 10'd254, 12'd508},
    {2'd0, 2'b01, 10'd100, 12'd0}
  };

  function automatic int top_of(input logic [1:0] s);
    return (s == 2'd0) ? 255 : (s == 2'd1) ? 511 : 1023;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input int d, input int t);
    if (!m[1]) return "R8";
    if (d == 0 || d >= t) return "R9";
    return m[0] ? "R7" : "R6";
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata = 10'(v);
    cmp_wr = 1'b1;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic clr_ovf();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  // Returns at the first negedge where the turnaround request is seen.
  task automatic sync_ovf();
    while (!ovf_irq) @(negedge clk);
  endtask

  // Counts high samples over one period starting at a turnaround.
  task automatic window(input int t, input bit do_wr, input int wv, output int hi);
    hi = 0;
    for (int i = 0; i < 2 * t; i++) begin
      if (i == 0) ovf_clr = 1'b1;
      if (i == 1) begin
        ovf_clr = 1'b0;
        if (do_wr) begin cmp_wdata = 10'(wv); cmp_wr = 1'b1; end
      end
      if (i == 2) cmp_wr = 1'b0;
      hi += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic settle(input int t);
    int d;
    clr_ovf();
    repeat (3) begin sync_ovf(); window(t, 1'b0, 0, d); end
    sync_ovf();
  endtask

  initial begin
    #950000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, hi, t;
    logic p0;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk(int'(pwm_out), 0, "R12 pwm in reset");
    chk(int'(ovf_irq), 0, "R12 ovf_irq in reset");
    chk(int'(cmp_irq), 0, "R12 cmp_irq in reset");

    // R2: first turnaround after reset release, output low with zero duty
    ovf_ie = 1'b1; cmp_ie = 1'b1; glb_ie = 1'b1;
    run = 1'b1; top_sel = 2'd0; out_mode = 2'b10;
    rst_n = 1'b1;
    k = 0; hi = 0;
    do begin
      @(negedge clk);
      k++;
      hi += int'(pwm_out);
    end while (!ovf_irq && k < 3000);
    chk(k, 511, "R2 first turnaround after reset");
    chk(hi, 0, "R12 output low after reset");

    // R6 R7 R8 R9: table of modes and duty values
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      top_sel = VEC[v][25:24];
      out_mode = VEC[v][23:22];
      wr_cmp(int'(VEC[v][21:12]));
      t = top_of(top_sel);
      settle(t);
      window(t, 1'b0, 0, hi);
      chk(hi, int'(VEC[v][11:0]),
          $sformatf("%s vector %0d", tag_of(VEC[v][23:22], int'(VEC[v][21:12]), t), v));
    end

    // R1 R2: turnaround spacing with TOP=511
    top_sel = 2'd1; out_mode = 2'b10;
    settle(511);
    ovf_clr = 1'b1; k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) ovf_clr = 1'b0;
    end while (!ovf_irq && k < 3000);
    chk(k, 1022, "R1 period 2*TOP between turnarounds");

    // R3: enable gating of a held turnaround flag
    glb_ie = 1'b0; #0.5;
    chk(int'(ovf_irq), 0, "R3 ovf gated by global enable");
    glb_ie = 1'b1; ovf_ie = 1'b0; #0.5;
    chk(int'(ovf_irq), 0, "R3 ovf gated by local enable");
    ovf_ie = 1'b1; #0.5;
    chk(int'(ovf_irq), 1, "R3 ovf flag kept while gated");

    // R5: clear, then clear on the same edge as a set
    top_sel = 2'd0;
    settle(255);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(int'(ovf_irq), 0, "R5 clear strobe empties flag");
    repeat (2 * 255 - 2) @(negedge clk);
    chk(int'(ovf_irq), 0, "R5 flag quiet before next turn");
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(int'(ovf_irq), 1, "R5 set wins over same-edge clear");

    // R4: match flag timing, duty 50
    @(negedge clk);
    wr_cmp(50);
    settle(255);
    cmp_clr = 1'b1; k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) cmp_clr = 1'b0;
    end while (!cmp_irq && k < 600);
    chk(k, 50, "R4 match flag latency");
    cmp_ie = 1'b0; #0.5;
    chk(int'(cmp_irq), 0, "R3 cmp gated by local enable");
    cmp_ie = 1'b1; #0.5;
    chk(int'(cmp_irq), 1, "R3 cmp flag kept while gated");

    // R10: duty change on the rising half takes effect at the ceiling
    @(negedge clk);
    wr_cmp(40);
    settle(255);
    window(255, 1'b0, 0, hi);
    chk(hi, 80, "R10 steady duty 40");
    sync_ovf();
    window(255, 1'b1, 100, hi);
    chk(hi, 140, "R10 old value rising, new value falling");
    sync_ovf();
    window(255, 1'b0, 0, hi);
    chk(hi, 200, "R10 new value whole period");

    // R11: stopped counter freezes output and flags
    repeat (37) @(negedge clk);
    run = 1'b0;
    clr_ovf();
    cmp_clr = 1'b1;
    @(negedge clk);
    cmp_clr = 1'b0;
    p0 = pwm_out;
    k = 0; hi = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (pwm_out !== p0) k++;
      if (ovf_irq || cmp_irq) hi++;
    end
    chk(k, 0, "R11 output frozen while stopped");
    chk(hi, 0, "R11 no flag set while stopped");
    run = 1'b1;

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule